// File: doc/BRIEF.md
# Snooze-Mode Conversion Sequencer

This controller lets an external hardware trigger run one analog-to-digital conversion while the processor sleeps in its stop state, so the processor is not woken for every sample. When the chip enters stop with the snooze enable set and a legal configuration, the sequencer waits for a trigger. It then steps through a wake-up transition delay, an analog power settling delay and a conversion window. Each of these lengths is a cycle count taken from input ports. After the conversion it holds a one-cycle completion phase. A window checker outside the block answers in that cycle with its interrupt, and that answer decides whether the processor is woken or the sequencer goes back to waiting.

Before it arms, the block checks the configuration. The system clock must be the fast internal oscillator, the trigger mode must be hardware trigger with wait, and conversion must be one-shot. If any of these fails, an error flag is raised and the sequencer stays idle. A trigger that arrives while a conversion sequence is running is dropped and latches an overrun flag. Because a sequence always runs to completion, accepted triggers are always at least transition + settling + conversion + 2 cycles apart.

Top module: `lpseq_top`

## Requirements
- R1: After reset, `state` is IDLE and `wakeReq`, `convStart`, `anaPowerOn`, `cfgErr` and `overrun` are low. State codes: IDLE=0, STOPPED=1, TRANSITION=2, STABILIZE=3, CONVERT=4, DONE=5, WAKE=6.
- R2: In IDLE, with `stopMode`=1, `snoozeEn`=1 and a legal configuration, `state` is STOPPED one cycle later. With `snoozeEn`=0 the block stays IDLE and raises no error.
- R3: With `stopMode`=1 and `snoozeEn`=1 in IDLE, `clkIsHsOsc`=0 makes the configuration illegal. `cfgErr` is then set one cycle later and the block stays IDLE.
- R4: Only `trigMode`=2 (hardware trigger with wait) is legal. Codes 0 (software), 1 (hardware, no wait) and 3 all give the R3 error behaviour.
- R5: `seqConv`=1 (sequential conversion) gives the R3 error behaviour. One-shot conversion (`seqConv`=0) is required.
- R6: A `hwTrig` pulse in STOPPED produces TRANSITION for `tranCycles` cycles, then STABILIZE for `stabCycles` cycles, then CONVERT for `convCycles` cycles, then DONE for one cycle. `anaPowerOn` is high during STABILIZE and CONVERT. `convStart` is high only in the first CONVERT cycle.
- R7: A programmed length of 0 for any phase behaves as a length of 1.
- R8: If `irqIn`=1 in the DONE cycle, `state` becomes WAKE and `wakeReq` stays high until `stopMode` falls. The cycle after that, `state` is IDLE.
- R9: If `irqIn`=0 in DONE, `state` returns to STOPPED. A trigger in that first STOPPED cycle is accepted, which is the minimum trigger spacing of T+S+C+2 cycles.
- R10: A `hwTrig` during TRANSITION, STABILIZE, CONVERT or DONE is ignored: the phase timing does not change and `overrun` is set one cycle later.
- R11: Whenever `stopMode` is low, `cfgErr` and `overrun` are cleared, and STOPPED returns to IDLE one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopMode | input | 1 | Chip is in stop state |
| hwTrig | input | 1 | Hardware conversion trigger pulse |
| clkIsHsOsc | input | 1 | System clock is the fast internal oscillator |
| trigMode | input | 2 | Trigger mode code (2 = hardware with wait) |
| seqConv | input | 1 | Sequential conversion selected |
| snoozeEn | input | 1 | Snooze operation enable |
| irqIn | input | 1 | Window checker interrupt, sampled in DONE |
| tranCycles | input | CNT_W | Stop-to-snooze transition length |
| stabCycles | input | CNT_W | Power settling length |
| convCycles | input | CNT_W | Conversion length |
| state | output | 3 | Current sequencer state code |
| convStart | output | 1 | One-cycle conversion start strobe |
| anaPowerOn | output | 1 | Analog power request |
| doneStrobe | output | 1 | Completion phase, asks for the window result |
| wakeReq | output | 1 | Wake the processor |
| cfgErr | output | 1 | Illegal snooze configuration seen |
| overrun | output | 1 | Trigger arrived while busy |

## Verification
The bench builds the block with the default CNT_W of 8 and drives phase lengths of 3, 2 and 4 cycles. These short lengths let every state boundary be checked cycle by cycle, together with the one-cycle DONE window and the back-to-back trigger at the minimum spacing. All-zero lengths are also driven to reach the clamp to one cycle. The same width admits lengths up to 255, so counter load and count-down are exercised without long runs.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_STOPPED = 3'd1,
    ST_TRAN    = 3'd2,
    ST_STAB    = 3'd3,
    ST_CONV    = 3'd4,
    ST_DONE    = 3'd5,
    ST_WAKE    = 3'd6
  } seqState_t;

  localparam logic [1:0] TMODE_HW_WAIT = 2'd2;

  typedef enum logic [1:0] {
    SEL_TRAN = 2'd0,
    SEL_STAB = 2'd1,
    SEL_CONV = 2'd2
  } cntSel_t;

  typedef struct packed {
    logic    loadCnt;
    cntSel_t cntSel;
    logic    startConv;
    logic    setErr;
    logic    setOvr;
    logic    clrFlags;
  } seqStrobe_t;

endpackage

// File: rtl/lpseq_datapath.sv
module lpseq_datapath
  import lpseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             clkIsHsOsc,
  input  logic [1:0]       trigMode,
  input  logic             seqConv,
  input  logic [CNT_W-1:0] tranCycles,
  input  logic [CNT_W-1:0] stabCycles,
  input  logic [CNT_W-1:0] convCycles,
  output logic             legalCfg,
  output logic             cntLast,
  output logic             convStart,
  output logic             cfgErr,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rawLen;
  logic [CNT_W-1:0] loadLen;

  assign legalCfg = clkIsHsOsc && (trigMode == TMODE_HW_WAIT) && !seqConv;

  always_comb begin
    unique case (strb.cntSel)
      SEL_STAB: rawLen = stabCycles;
      SEL_CONV: rawLen = convCycles;
      default:  rawLen = tranCycles;
    endcase
    loadLen = (rawLen == '0) ? ONE : rawLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadCnt) begin
      cnt <= loadLen;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntLast = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart <= 1'b0;
      cfgErr    <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      convStart <= strb.startConv;
      if (strb.setErr)        cfgErr <= 1'b1;
      else if (strb.clrFlags) cfgErr <= 1'b0;
      if (strb.setOvr)        overrun <= 1'b1;
      else if (strb.clrFlags) overrun <= 1'b0;
    end
  end

  // R7: a loaded phase length is never zero
  p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (cnt != '0));

endmodule

// File: rtl/lpseq_control.sv
module lpseq_control
  import lpseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopMode,
  input  logic       snoozeEn,
  input  logic       hwTrig,
  input  logic       irqIn,
  input  logic       legalCfg,
  input  logic       cntLast,
  output seqStrobe_t strb,
  output seqState_t  curState
);

  seqState_t nxtState;
  logic      busy;

  assign busy = (curState == ST_TRAN) || (curState == ST_STAB) ||
                (curState == ST_CONV) || (curState == ST_DONE);

  always_comb begin
    nxtState  = curState;
    strb      = '0;
    strb.cntSel   = SEL_TRAN;
    strb.clrFlags = !stopMode;
    strb.setOvr   = busy && hwTrig;
    unique case (curState)
      ST_IDLE: begin
        if (stopMode && snoozeEn) begin
          if (legalCfg) nxtState = ST_STOPPED;
          else          strb.setErr = 1'b1;
        end
      end
      ST_STOPPED: begin
        if (!stopMode) begin
          nxtState = ST_IDLE;
        end else if (hwTrig) begin
          nxtState     = ST_TRAN;
          strb.loadCnt = 1'b1;
          strb.cntSel  = SEL_TRAN;
        end
      end
      ST_TRAN: begin
        if (cntLast) begin
          nxtState     = ST_STAB;
          strb.loadCnt = 1'b1;
          strb.cntSel  = SEL_STAB;
        end
      end
      ST_STAB: begin
        if (cntLast) begin
          nxtState       = ST_CONV;
          strb.loadCnt   = 1'b1;
          strb.cntSel    = SEL_CONV;
          strb.startConv = 1'b1;
        end
      end
      ST_CONV: begin
        if (cntLast) nxtState = ST_DONE;
      end
      ST_DONE: begin
        nxtState = irqIn ? ST_WAKE : ST_STOPPED;
      end
      ST_WAKE: begin
        if (!stopMode) nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  // R6: the completion phase lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DONE) |=> (curState != ST_DONE));

endmodule

// File: rtl/lpseq_top.sv
module lpseq_top
  import lpseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopMode,
  input  logic             hwTrig,
  input  logic             clkIsHsOsc,
  input  logic [1:0]       trigMode,
  input  logic             seqConv,
  input  logic             snoozeEn,
  input  logic             irqIn,
  input  logic [CNT_W-1:0] tranCycles,
  input  logic [CNT_W-1:0] stabCycles,
  input  logic [CNT_W-1:0] convCycles,
  output logic [2:0]       state,
  output logic             convStart,
  output logic             anaPowerOn,
  output logic             doneStrobe,
  output logic             wakeReq,
  output logic             cfgErr,
  output logic             overrun
);

  seqStrobe_t strb;
  seqState_t  curState;
  logic       legalCfg;
  logic       cntLast;

  lpseq_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stopMode (stopMode),
    .snoozeEn (snoozeEn),
    .hwTrig   (hwTrig),
    .irqIn    (irqIn),
    .legalCfg (legalCfg),
    .cntLast  (cntLast),
    .strb     (strb),
    .curState (curState)
  );

  lpseq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .clkIsHsOsc (clkIsHsOsc),
    .trigMode   (trigMode),
    .seqConv    (seqConv),
    .tranCycles (tranCycles),
    .stabCycles (stabCycles),
    .convCycles (convCycles),
    .legalCfg   (legalCfg),
    .cntLast    (cntLast),
    .convStart  (convStart),
    .cfgErr     (cfgErr),
    .overrun    (overrun)
  );

  assign state      = curState;
  assign anaPowerOn = (curState == ST_STAB) || (curState == ST_CONV);
  assign doneStrobe = (curState == ST_DONE);
  assign wakeReq    = (curState == ST_WAKE);

  // R3 (also covers R4, R5): an illegal setup keeps the block idle and flags it
  p_illegal_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && stopMode && snoozeEn && !legalCfg)
      |=> (curState == ST_IDLE && cfgErr));

  // R10: a trigger during a running sequence latches overrun
  p_busy_trig_ovr_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_TRAN || curState == ST_STAB || curState == ST_CONV ||
      curState == ST_DONE) && hwTrig) |=> overrun);

  // R8: interrupt at completion wakes the processor
  p_done_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && irqIn) |=> wakeReq);

  // R6: start strobe is a single pulse with analog power on
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  p_start_power_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> anaPowerOn);

endmodule

// File: tb/lpseq_top_test.sv
`timescale 1ns/1ps
module lpseq_top_test;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             stopMode = 1'b0, hwTrig = 1'b0, clkIsHsOsc = 1'b1;
  logic [1:0]       trigMode = 2'd2;
  logic             seqConv = 1'b0, snoozeEn = 1'b0, irqIn = 1'b0;
  logic [CNT_W-1:0] tranCycles = 8'd3, stabCycles = 8'd2, convCycles = 8'd4;
  logic [2:0]       state;
  logic             convStart, anaPowerOn, doneStrobe, wakeReq, cfgErr, overrun;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lpseq_top #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .hwTrig(hwTrig),
    .clkIsHsOsc(clkIsHsOsc), .trigMode(trigMode), .seqConv(seqConv),
    .snoozeEn(snoozeEn), .irqIn(irqIn), .tranCycles(tranCycles),
    .stabCycles(stabCycles), .convCycles(convCycles), .state(state),
    .convStart(convStart), .anaPowerOn(anaPowerOn), .doneStrobe(doneStrobe),
    .wakeReq(wakeReq), .cfgErr(cfgErr), .overrun(overrun)
  );

  // [6] fast osc, [5:4] trigger mode, [3] sequential, [2] enable,
  // [1] expect STOPPED, [0] expect error
  localparam logic [6:0] CFG_VEC [8] = '{
    7'b1_10_0_1_1_0,  // R2 legal
    7'b1_10_0_0_0_0,  // R2 enable low
    7'b0_10_0_1_0_1,  // R3 slow clock
    7'b1_00_0_1_0_1,  // R4 software trigger
    7'b1_01_0_1_0_1,  // R4 no-wait
    7'b1_11_0_1_0_1,  // R4 code 3
    7'b1_10_1_1_0_1,  // R5 sequential
    7'b0_01_1_0_0_0   // R2 illegal but disabled
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    stopMode = 1'b0; snoozeEn = 1'b0; tick();
    clkIsHsOsc = 1'b1; trigMode = 2'd2; seqConv = 1'b0;
    stopMode = 1'b1; snoozeEn = 1'b1; tick();
  endtask

  // trigger now (state STOPPED), check each phase; stray = cycle to inject a trigger
  task automatic runSeq(input int t, input int s, input int c, input bit irq, input int stray);
    int te, se, ce, d;
    te = (t == 0) ? 1 : t; se = (s == 0) ? 1 : s; ce = (c == 0) ? 1 : c;
    tranCycles = CNT_W'(t); stabCycles = CNT_W'(s); convCycles = CNT_W'(c);
    irqIn = irq;
    hwTrig = 1'b1; tick(); hwTrig = 1'b0;
    d = 1;
    while (d <= te + se + ce + 1) begin
      int expSt;
      if (d <= te) expSt = 2;
      else if (d <= te + se) expSt = 3;
      else if (d <= te + se + ce) expSt = 4;
      else expSt = 5;
      chk("R6 phase state", state, expSt);
      chk("R6 power", anaPowerOn, (expSt == 3 || expSt == 4) ? 1 : 0);
      chk("R6 start strobe", convStart, (d == te + se + 1) ? 1 : 0);
      hwTrig = (d == stray);
      tick();
      hwTrig = 1'b0;
      if (d == stray) chk("R10 overrun set", overrun, 1);
      d++;
    end
    chk(irq ? "R8 wake state" : "R9 back to stopped", state, irq ? 6 : 1);
    irqIn = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 state", state, 0);
    chk("R1 outputs", {wakeReq, convStart, anaPowerOn, cfgErr, overrun}, 0);
    rstN = 1'b1;
    tick();

    for (int i = 0; i < 8; i++) begin
      stopMode = 1'b0; snoozeEn = 1'b0; tick();
      clkIsHsOsc = CFG_VEC[i][6]; trigMode = CFG_VEC[i][5:4];
      seqConv = CFG_VEC[i][3]; snoozeEn = CFG_VEC[i][2]; stopMode = 1'b1;
      tick();
      chk("R2-entry state R3 R4 R5", state, CFG_VEC[i][1] ? 1 : 0);
      chk("R3 R4 R5 error flag", cfgErr, CFG_VEC[i][0]);
    end
    stopMode = 1'b0; tick();
    chk("R11 error cleared", cfgErr, 0);

    // R6 / R9 normal sequence, then back-to-back at minimum spacing
    arm();
    runSeq(3, 2, 4, 1'b0, 0);
    runSeq(3, 2, 4, 1'b0, 0);
    chk("R10 no overrun without stray", overrun, 0);

    // R10 triggers during transition and conversion
    runSeq(3, 2, 4, 1'b0, 2);
    runSeq(3, 2, 4, 1'b0, 8);
    // R11 leaving stop clears flags and returns idle
    stopMode = 1'b0; tick();
    chk("R11 idle", state, 0);
    chk("R11 overrun cleared", overrun, 0);

    // R7 zero lengths
    arm();
    runSeq(0, 0, 0, 1'b0, 0);

    // R8 wake path
    runSeq(1, 1, 2, 1'b1, 0);
    chk("R8 wakeReq", wakeReq, 1);
    hwTrig = 1'b1; tick(); hwTrig = 1'b0; tick();
    chk("R8 wake held", state, 6);
    stopMode = 1'b0; tick();
    chk("R8 idle after stop drops", state, 0);
    chk("R8 wakeReq low", wakeReq, 0);

    // R10 trigger in DONE (T=1,S=1,C=1 -> DONE at d=4)
    arm();
    runSeq(1, 1, 1, 1'b0, 4);
    stopMode = 1'b0; tick();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule